// File: doc/BRIEF.md
# Elastic Postponing Refresh Scheduler

This block decides when one DRAM rank should be refreshed. A nominal interval timer runs on a timebase tick. At the start of each interval the rank earns one owed refresh. The block does not issue that refresh on a fixed schedule. It holds the owed refreshes as credit and raises a request when the command scheduler's read and write queues for the rank have stayed empty long enough to count as a lull. Eight intervals form one allowance window. When the time left in the window drops to the owed count times the refresh completion time plus a safety margin, the block flags the refresh as urgent and requests it whether or not traffic is pending.

The command scheduler answers a raised request with a one-cycle done pulse when it has issued the refresh. The block then holds the rank busy for the completion time. A high-temperature flag halves the nominal interval. Command encoding and the precharge of open rows before a refresh belong to the scheduler.

The control is a three-state machine:
- `ST_IDLE`: no request is raised. It moves to `ST_REQ` when credit is above zero and either a lull or urgency holds.
- `ST_REQ`: the request is raised. It moves to `ST_BUSY` on a done pulse. It falls back to `ST_IDLE` when neither a lull nor urgency holds any longer.
- `ST_BUSY`: the rank is unavailable. It returns to `ST_IDLE` on the tick that completes the busy time.

Top module: `refresh_elastic_sched`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the request, urgent and busy outputs are low and the owed count is 0.
- R2: One refresh is earned on the first tick after reset and then once every TREFI_TICKS ticks, each time the interval counter is at zero on a tick.
- R3: The owed count never exceeds MAX_OWED, which is 8 by default. A refresh earned while the count is already full is discarded.
- R4: A lull holds once `queues_empty_i` has been high on LULL_CYCLES consecutive clock edges. A single edge with it low restarts the count.
- R5: The request rises one cycle after an edge at which the owed count is above zero, the rank is not busy, and a lull or urgency holds. Without a done pulse, the request is withdrawn one cycle after an edge at which neither holds.
- R6: A done pulse while the request is high lowers the owed count by one. The request then drops and busy rises on the next cycle, and busy stays high for TRFC_TICKS ticks.
- R7: A done pulse while the request is low changes nothing: no busy period starts and the owed count is kept.
- R8: The request is never high while busy is high.
- R9: Urgent is high exactly when the owed count c is above zero and the remaining window time is at most c*TRFC_TICKS+MARGIN_TICKS. The remaining time is (7-w)*L plus (L-n), where w is the interval index 0..7, n is the tick count within the interval and L is the current interval length, and the (L-n) term counts as 1 if n is at least L. With continuous traffic, urgency alone clears every owed refresh of a window before the window ends.
- R10: While `hot_i` is high, the interval length is TREFI_TICKS/2.
- R11: The interval timer and the busy timer advance only on cycles with `tick_i` high. The lull count advances on every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timebase tick enabling the interval and busy timers |
| queues_empty_i | input | 1 | Read and write queues for the rank are empty |
| hot_i | input | 1 | High temperature; halves the interval |
| ref_done_i | input | 1 | Scheduler has issued the requested refresh |
| ref_req_o | output | 1 | Refresh request |
| ref_urgent_o | output | 1 | Refresh must be issued regardless of traffic |
| rank_busy_o | output | 1 | Rank unavailable during refresh completion |

## Verification
Each state change is registered, so the request and busy outputs move one clock after the edge that sees their cause. A lull therefore produces a request after LULL_CYCLES+1 edges of empty queues. A done pulse sampled at one edge shows as busy after that same edge, and busy clears TRFC_TICKS ticks later. Urgent is combinational from registered state and `hot_i`, so it follows the same edge that updates the counters. The bench drives inputs on the falling edge and advances its behavioural model on the rising edge. It compares the outputs 5 ns after each rising edge. Its directed checks count busy rises over spans whose length is chosen so that the number of earned refreshes is known exactly.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_BUSY = 2'd2
    } refsch_state_e;

endpackage

// File: rtl/refsch_interval_timer.sv
// Nominal interval timer and allowance-window position.
module refsch_interval_timer #(
    parameter int TREFI_TICKS   = 390,
    parameter int WIN_INTERVALS = 8,
    parameter int REM_W         = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             hot_i,
    output logic             earn_o,
    output logic [REM_W-1:0] rem_o
);
    localparam int IVL_W = $clog2(TREFI_TICKS + 1);
    localparam int WIN_W = $clog2(WIN_INTERVALS);
    localparam logic [IVL_W-1:0] LIM_COOL = IVL_W'(TREFI_TICKS);
    localparam logic [IVL_W-1:0] LIM_HOT  = IVL_W'(TREFI_TICKS / 2);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_INTERVALS - 1);

    logic [IVL_W-1:0] ivl_q;
    logic [WIN_W-1:0] win_q;
    logic [IVL_W-1:0] limit;
    logic [IVL_W-1:0] ivl_left;
    logic             wrap;

    assign limit = hot_i ? LIM_HOT : LIM_COOL;
    assign wrap  = (ivl_q >= limit - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ivl_q <= '0;
            win_q <= '0;
        end else if (tick_i) begin
            if (wrap) begin
                ivl_q <= '0;
                win_q <= (win_q == WIN_LAST) ? '0 : win_q + 1'b1;
            end else begin
                ivl_q <= ivl_q + 1'b1;
            end
        end
    end

    assign earn_o   = tick_i && (ivl_q == '0);
    assign ivl_left = (ivl_q >= limit) ? IVL_W'(1) : (limit - ivl_q);

    always_comb begin
        logic [REM_W-1:0] whole_left;
        whole_left = REM_W'(WIN_INTERVALS - 1) - REM_W'(win_q);
        rem_o      = whole_left * REM_W'(limit) + REM_W'(ivl_left);
    end

endmodule

// File: rtl/refsch_lull_detect.sv
// Counts consecutive empty-queue cycles; lull once the run is long enough.
module refsch_lull_detect #(
    parameter int LULL_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_i,
    output logic lull_o
);
    localparam int LW = $clog2(LULL_CYCLES + 1);
    localparam logic [LW-1:0] RUN_FULL = LW'(LULL_CYCLES);

    logic [LW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!idle_i) begin
            run_q <= '0;
        end else if (run_q != RUN_FULL) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign lull_o = (run_q == RUN_FULL);

endmodule

// File: rtl/refsch_credit.sv
// Saturating count of owed refreshes.
module refsch_credit #(
    parameter int MAX_OWED = 8,
    parameter int CRED_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              earn_i,
    input  logic              spend_i,
    output logic [CRED_W-1:0] credit_o
);
    localparam logic [CRED_W-1:0] CRED_FULL = CRED_W'(MAX_OWED);

    logic [CRED_W-1:0] cred_q;
    logic              earn_ok;

    assign earn_ok = earn_i && (cred_q != CRED_FULL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cred_q <= '0;
        end else begin
            unique case ({earn_ok, spend_i})
                2'b10:   cred_q <= cred_q + 1'b1;
                2'b01:   cred_q <= cred_q - 1'b1;
                default: cred_q <= cred_q;
            endcase
        end
    end

    assign credit_o = cred_q;

endmodule

// File: rtl/refresh_elastic_sched.sv
module refresh_elastic_sched #(
    parameter int TREFI_TICKS  = 390,
    parameter int TRFC_TICKS   = 18,
    parameter int LULL_CYCLES  = 8,
    parameter int MARGIN_TICKS = 64,
    parameter int MAX_OWED     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic queues_empty_i,
    input  logic hot_i,
    input  logic ref_done_i,
    output logic ref_req_o,
    output logic ref_urgent_o,
    output logic rank_busy_o
);
    import refsch_pkg::*;

    localparam int CRED_W = $clog2(MAX_OWED + 1);
    localparam int REM_W  = $clog2(MAX_OWED * TREFI_TICKS + 1) + 1;
    localparam int BW     = $clog2(TRFC_TICKS + 1);
    localparam logic [BW-1:0] BUSY_LAST = BW'(TRFC_TICKS - 1);

    refsch_state_e     state_q, state_d;
    logic [BW-1:0]     busy_q;
    logic [CRED_W-1:0] credit_q;
    logic [REM_W-1:0]  rem;
    logic              earn;
    logic              lull;
    logic              urgent;
    logic              spend;
    logic              busy_end;
    logic              want;

    refsch_interval_timer #(
        .TREFI_TICKS  (TREFI_TICKS),
        .WIN_INTERVALS(MAX_OWED),
        .REM_W        (REM_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_i(tick_i),
        .hot_i (hot_i),
        .earn_o(earn),
        .rem_o (rem)
    );

    refsch_lull_detect #(
        .LULL_CYCLES(LULL_CYCLES)
    ) u_lull (
        .clk   (clk),
        .rst_n (rst_n),
        .idle_i(queues_empty_i),
        .lull_o(lull)
    );

    refsch_credit #(
        .MAX_OWED(MAX_OWED),
        .CRED_W  (CRED_W)
    ) u_credit (
        .clk     (clk),
        .rst_n   (rst_n),
        .earn_i  (earn),
        .spend_i (spend),
        .credit_o(credit_q)
    );

    // Deadline pressure: remaining window time vs. time to clear what is owed.
    always_comb begin
        logic [31:0] need;
        need   = 32'(credit_q) * 32'(TRFC_TICKS) + 32'(MARGIN_TICKS);
        urgent = (credit_q != '0) && (32'(rem) <= need);
    end

    assign want     = lull || urgent;
    assign spend    = (state_q == ST_REQ) && ref_done_i;
    assign busy_end = tick_i && (busy_q == BUSY_LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if ((credit_q != '0) && want) state_d = ST_REQ;
            ST_REQ: begin
                if (ref_done_i)  state_d = ST_BUSY;
                else if (!want)  state_d = ST_IDLE;
            end
            ST_BUSY: if (busy_end) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  busy_q <= '0;
        else if (state_q != ST_BUSY) busy_q <= '0;
        else if (tick_i)             busy_q <= busy_q + 1'b1;
    end

    always_comb begin
        ref_req_o    = (state_q == ST_REQ);
        rank_busy_o  = (state_q == ST_BUSY);
        ref_urgent_o = urgent;
    end

endmodule

// File: rtl/refsch_checker.sv
module refsch_checker #(
    parameter int MAX_OWED = 8,
    localparam int CRED_W  = $clog2(MAX_OWED + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              busy,
    input logic              urgent,
    input logic              done,
    input logic              earn,
    input logic [CRED_W-1:0] credit
);
    AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        credit <= CRED_W'(MAX_OWED)); // R3

    AST_EARN_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        earn && !(req && done) && (credit != CRED_W'(MAX_OWED))
        |=> credit == $past(credit) + 1'b1); // R2

    AST_REQ_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> credit != '0); // R5

    AST_DONE_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req && done |=> busy && !req); // R6

    AST_SPEND_SUBTRACTS: assert property (@(posedge clk) disable iff (!rst_n)
        req && done && !earn |=> credit == $past(credit) - 1'b1); // R6

    AST_STRAY_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !req && !busy && done |=> !busy); // R7

    AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && busy)); // R8

    AST_URGENT_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        urgent |-> credit != '0); // R9

endmodule

bind refresh_elastic_sched refsch_checker #(.MAX_OWED(MAX_OWED)) u_refsch_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (ref_req_o),
    .busy  (rank_busy_o),
    .urgent(ref_urgent_o),
    .done  (ref_done_i),
    .earn  (earn),
    .credit(credit_q)
);

// File: tb/test_refresh_elastic_sched.sv
`timescale 1ns/1ps
module test_refresh_elastic_sched;
    localparam int P_TREFI  = 100;
    localparam int P_TRFC   = 6;
    localparam int P_LULL   = 4;
    localparam int P_MARGIN = 32;
    localparam int P_MAX    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic empty = 1'b0;
    logic hot = 1'b0;
    logic ack_en = 1'b0;
    logic ack_auto = 1'b0;
    logic ack_man = 1'b0;
    logic done;
    logic req, urg, busy;

    int n_checks = 0;
    int n_fail = 0;
    int rises = 0;
    int cyc = 0;
    bit urg_seen = 0;
    bit prev_busy = 0;

    // behavioural reference state
    int m_ivl = 0, m_w = 0, m_credit = 0, m_lcnt = 0, m_bcnt = 0, m_st = 0;

    assign done = ack_auto | ack_man;

    always #10 clk = ~clk;

    refresh_elastic_sched #(
        .TREFI_TICKS (P_TREFI),
        .TRFC_TICKS  (P_TRFC),
        .LULL_CYCLES (P_LULL),
        .MARGIN_TICKS(P_MARGIN),
        .MAX_OWED    (P_MAX)
    ) i_refresh_elastic_sched (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick),
        .queues_empty_i(empty),
        .hot_i         (hot),
        .ref_done_i    (done),
        .ref_req_o     (req),
        .ref_urgent_o  (urg),
        .rank_busy_o   (busy)
    );

    function automatic bit model_urgent();
        int lim, left, rem;
        lim  = hot ? P_TREFI / 2 : P_TREFI;
        left = (m_ivl >= lim) ? 1 : lim - m_ivl;
        rem  = (P_MAX - 1 - m_w) * lim + left;
        return (m_credit > 0) && (rem <= m_credit * P_TRFC + P_MARGIN);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // reference model step
    always @(posedge clk) begin
        int lim, nst;
        bit lull, u, inc, dec;
        if (!rst_n) begin
            m_ivl = 0; m_w = 0; m_credit = 0; m_lcnt = 0; m_bcnt = 0; m_st = 0;
        end else begin
            lull = (m_lcnt >= P_LULL);
            u    = model_urgent();
            nst  = m_st;
            case (m_st)
                0: if (m_credit > 0 && (lull || u)) nst = 1;
                1: if (done) nst = 2; else if (!(lull || u)) nst = 0;
                default: if (tick && m_bcnt == P_TRFC - 1) nst = 0;
            endcase
            inc = tick && (m_ivl == 0) && (m_credit < P_MAX);
            dec = (m_st == 1) && done;
            if (m_st != 2) m_bcnt = 0;
            else if (tick) m_bcnt++;
            lim = hot ? P_TREFI / 2 : P_TREFI;
            if (tick) begin
                if (m_ivl >= lim - 1) begin
                    m_ivl = 0;
                    m_w = (m_w == P_MAX - 1) ? 0 : m_w + 1;
                end else m_ivl++;
            end
            if (!empty) m_lcnt = 0;
            else if (m_lcnt < P_LULL) m_lcnt++;
            m_credit = m_credit + int'(inc) - int'(dec);
            m_st = nst;
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #5;
        check(req == (m_st == 1), "R5", "request vs model", int'(req), int'(m_st == 1));
        check(busy == (m_st == 2), "R6", "busy vs model", int'(busy), int'(m_st == 2));
        check(urg == model_urgent(), "R9", "urgent vs model", int'(urg), int'(model_urgent()));
        if (busy && !prev_busy) rises++;
        prev_busy = busy;
        if (urg) urg_seen = 1;
    end

    always @(negedge clk) ack_auto <= ack_en && req;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 60000);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: quiet during reset
        check(!req && !urg && !busy, "R1", "outputs in reset",
              int'({req, urg, busy}), 0);
        rst_n = 1'b1;
        rises = 0;
        urg_seen = 0;
        @(negedge clk);
        check(!req && !urg && !busy, "R1", "outputs after release",
              int'({req, urg, busy}), 0);
    endtask

    initial begin
        // R4 / R5: lull detection and withdrawal
        do_reset();
        for (int k = 0; k < 6; k++) begin
            empty = 1'b1; repeat (3) @(negedge clk);
            empty = 1'b0; @(negedge clk);
        end
        check(req == 1'b0, "R4", "short empty runs give no lull", int'(req), 0);
        empty = 1'b1; repeat (6) @(negedge clk);
        check(req == 1'b1, "R4", "request after lull", int'(req), 1);
        empty = 1'b0; repeat (3) @(negedge clk);
        check(req == 1'b0, "R5", "request withdrawn on traffic", int'(req), 0);

        // R7: stray done while request low
        do_reset();
        ack_man = 1'b1; repeat (5) @(negedge clk);
        ack_man = 1'b0; repeat (2) @(negedge clk);
        check(busy == 1'b0, "R7", "busy after stray done", int'(busy), 0);
        empty = 1'b1; repeat (6) @(negedge clk);
        check(req == 1'b1, "R7", "credit kept after stray done", int'(req), 1);
        empty = 1'b0;

        // R2: one refresh per interval under lull
        ack_en = 1'b1;
        do_reset();
        empty = 1'b1;
        repeat (500) @(negedge clk);
        check(rises == 5, "R2", "refreshes in 5 intervals", rises, 5);

        // R10: hot halves the interval
        hot = 1'b1;
        do_reset();
        repeat (500) @(negedge clk);
        check(rises == 10, "R10", "refreshes in 500 cycles hot", rises, 10);
        hot = 1'b0;

        // R11: half-rate tick
        do_reset();
        for (int k = 0; k < 500; k++) begin
            tick = ~tick;
            @(negedge clk);
        end
        tick = 1'b1;
        check(rises == 3, "R11", "refreshes with half-rate tick", rises, 3);

        // R9: urgency alone clears a window under continuous traffic
        empty = 1'b0;
        do_reset();
        repeat (790) @(negedge clk);
        check(urg_seen, "R9", "urgent raised under traffic", int'(urg_seen), 1);
        check(rises == 8, "R9", "owed refreshes cleared in window", rises, 8);

        // R3: saturation at 8 owed, then drain
        ack_en = 1'b0;
        do_reset();
        repeat (1002) @(negedge clk);
        check(busy == 1'b0, "R3", "no refresh without done", int'(busy), 0);
        ack_en = 1'b1;
        empty = 1'b1;
        rises = 0;
        repeat (90) @(negedge clk);
        check(rises == 8, "R3", "refreshes drained after saturation", rises, 8);
        check(req == 1'b0, "R3", "no request once drained", int'(req), 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule